// File: doc/BRIEF.md
# SDRAM Bank State Tracker

This block listens to the command pins of a single-rank, four-bank SDRAM. It keeps a live picture of every bank: whether the bank is idle, holds an open row, is finishing a burst that will close it automatically, or is waiting out its precharge recovery time. It also stores the row address held open in each bank. Only the command, bank-select and address pins are observed. No data path is modelled, and refresh intervals are not timed.

Every command that the chip-select line enables is checked against the current bank picture. A command that breaks a rule produces a one-cycle error pulse with a code for the kind of violation, and it is then dropped: it changes no bank state. The burst length used for auto-precharge timing comes from a copy of the mode register, which is updated on each legal mode load. A monitor or protocol checker places this block beside a memory controller to catch sequencing bugs while they happen.

Top module: `sdram_bank_tracker`

## Requirements
- R1: The command is {cs_n_i, ras_n_i, cas_n_i, we_n_i}. The encodings are 0011 activate, 0101 read, 0100 write, 0010 precharge and 0000 mode load. The codes 0001 (refresh), 0110 (burst stop) and 0111 (no-op), and any pattern with cs_n_i high, change no bank state and raise no error.
- R2: An activate to an idle bank selected by ba_i opens that bank and stores addr_i as its row. bank_open_o[b] and row field b of open_row_o (bits b*12+11 down to b*12) show the change in the cycle after the edge.
- R3: An activate to a bank that is already open gives error code 2.
- R4: A read or write to an idle bank gives error code 1. A read or write to an open bank with addr_i[10] low is legal and leaves the bank open.
- R5: A precharge with addr_i[10] low closes the bank selected by ba_i. With addr_i[10] high it closes every open bank and ignores ba_i. A precharge to a bank that is already idle leaves that bank idle and starts no recovery.
- R6: A bank closed at edge k shows bank_busy_o high. Any activate, read, write or single-bank precharge to it at edges k+1 to k+T_RP-1 gives error code 3. From edge k+T_RP on the bank is idle. A precharge-all or a mode load while any bank is busy also gives code 3.
- R7: A read or write with addr_i[10] high at edge k and burst length L keeps the bank open until edge k+L. The bank then closes and recovers, and it is busy until it accepts commands again at edge k+L+T_RP.
- R8: A legal mode load sets the burst code from addr_i[2:0]. The codes are 000 for length 1, 001 for 2, 010 for 4, 011 for 8 and 111 for full page. The codes 100, 101 and 110 act as length 1.
- R9: A read or write with addr_i[10] high while the burst code is full page gives error code 5, and the bank stays open.
- R10: A mode load while no bank is busy but at least one bank is open gives error code 4.
- R11: A violation at an edge drives err_valid_o high, with err_code_o set to the code, for exactly the following cycle. The offending command changes no bank state, no row and no burst code.
- R12: After reset all banks are idle and not busy, all rows are zero, no error is shown, and the burst code is 010 (length 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, the command pins are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank select |
| addr_i | input | 12 | Address: row on activate, bit 10 as the precharge/auto-precharge flag, bits 2:0 as the burst code on mode load |
| bank_open_o | output | 4 | One bit per bank, high while a row is open |
| bank_busy_o | output | 4 | One bit per bank, high while the bank is in an auto-precharge burst or in recovery |
| open_row_o | output | 48 | Row held by each bank, 12 bits per bank, bank 0 in the lowest bits |
| err_valid_o | output | 1 | One-cycle pulse for an illegal command |
| err_code_o | output | 3 | Violation code: 1 access to an idle bank, 2 activate to an open bank, 3 bank busy, 4 mode load with a bank open, 5 auto-precharge with full page |

## Verification
Directed sequences drive each violation against a known bank picture. The recovery window is probed at its first, middle and last edges so that an off-by-one in the timer shows up as a wrong error code. Auto-precharge is run with burst lengths 1, 2, 4 and 8, which separates a close that follows the loaded burst code from one tied to a fixed length. Precharge-all runs with mixed open, idle and busy banks to test the A10 choice against the ba_i choice. A long stream of mixed commands is then compared edge by edge against a timestamp-based model, which catches wrong priorities between the error codes.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_ACT,
    OP_RD,
    OP_WR,
    OP_PRE,
    OP_LMR
  } op_e;

  typedef enum logic [1:0] {
    BK_IDLE,
    BK_OPEN,
    BK_APB,   // open, auto-precharge pending
    BK_RECOV
  } bank_st_e;

  typedef enum logic [2:0] {
    ERR_NONE      = 3'd0,
    ERR_RW_IDLE   = 3'd1,
    ERR_ACT_OPEN  = 3'd2,
    ERR_BUSY      = 3'd3,
    ERR_MODE_OPEN = 3'd4,
    ERR_AP_FULL   = 3'd5
  } err_e;

  localparam logic [2:0] BL_FULL = 3'b111;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_trk_pkg::*;
(
  input  logic [3:0] cmd_i,  // {cs, ras, cas, we}, active low
  output op_e        op_o
);

  always_comb begin
    op_o = OP_NONE;
    if (!cmd_i[3]) begin
      unique case (cmd_i[2:0])
        3'b011:  op_o = OP_ACT;
        3'b101:  op_o = OP_RD;
        3'b100:  op_o = OP_WR;
        3'b010:  op_o = OP_PRE;
        3'b000:  op_o = OP_LMR;
        default: op_o = OP_NONE;
      endcase
    end
  end

endmodule

// File: rtl/sdram_rule_check.sv
module sdram_rule_check
  import sdram_trk_pkg::*;
#(
  parameter int BA_W = 2,
  localparam int NB  = 1 << BA_W
) (
  input  op_e             op_i,
  input  logic [BA_W-1:0] ba_i,
  input  logic            ap_i,
  input  logic            full_page_i,
  input  logic [NB-1:0]   open_i,
  input  logic [NB-1:0]   busy_i,
  output err_e            err_o
);

  logic sel_open, sel_busy, any_open, any_busy;

  assign sel_open = open_i[ba_i];
  assign sel_busy = busy_i[ba_i];
  assign any_open = |open_i;
  assign any_busy = |busy_i;

  // busy outranks every other violation
  always_comb begin
    err_o = ERR_NONE;
    unique case (op_i)
      OP_ACT: begin
        if (sel_busy)      err_o = ERR_BUSY;
        else if (sel_open) err_o = ERR_ACT_OPEN;
      end
      OP_RD, OP_WR: begin
        if (sel_busy)                err_o = ERR_BUSY;
        else if (!sel_open)          err_o = ERR_RW_IDLE;
        else if (ap_i && full_page_i) err_o = ERR_AP_FULL;
      end
      OP_PRE: begin
        if (ap_i ? any_busy : sel_busy) err_o = ERR_BUSY;
      end
      OP_LMR: begin
        if (any_busy)      err_o = ERR_BUSY;
        else if (any_open) err_o = ERR_MODE_OPEN;
      end
      default: err_o = ERR_NONE;
    endcase
  end

endmodule

// File: rtl/sdram_bank_ctx.sv
module sdram_bank_ctx
  import sdram_trk_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int T_RP  = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic             ap_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [CNT_W-1:0] burst_i,
  output logic             open_o,
  output logic             busy_o,
  output logic [ROW_W-1:0] row_o
);

  localparam bit             RP_SKIP = (T_RP <= 1);
  localparam logic [CNT_W-1:0] RP_LOAD = CNT_W'(RP_SKIP ? 1 : T_RP - 1);

  bank_st_e         st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= BK_IDLE;
      cnt_q <= '0;
      row_q <= '0;
    end else begin
      unique case (st_q)
        BK_IDLE: if (act_i) begin
          st_q  <= BK_OPEN;
          row_q <= row_i;
        end
        BK_OPEN: begin
          if (pre_i) begin
            st_q  <= RP_SKIP ? BK_IDLE : BK_RECOV;
            cnt_q <= RP_LOAD;
          end else if (ap_i) begin
            st_q  <= BK_APB;
            cnt_q <= burst_i;
          end
        end
        BK_APB: begin
          if (cnt_q == CNT_W'(1)) begin
            st_q  <= RP_SKIP ? BK_IDLE : BK_RECOV;
            cnt_q <= RP_LOAD;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        BK_RECOV: begin
          if (cnt_q == CNT_W'(1)) st_q <= BK_IDLE;
          else                    cnt_q <= cnt_q - CNT_W'(1);
        end
        default: st_q <= BK_IDLE;
      endcase
    end
  end

  assign open_o = (st_q == BK_OPEN) || (st_q == BK_APB);
  assign busy_o = (st_q == BK_APB) || (st_q == BK_RECOV);
  assign row_o  = row_q;

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_trk_pkg::*;
#(
  parameter int         BA_W        = 2,
  parameter int         ROW_W       = 12,
  parameter int         AP_BIT      = 10,
  parameter int         T_RP        = 3,
  parameter logic [2:0] RST_BL_CODE = 3'b010,
  localparam int        NB          = 1 << BA_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_n_i,
  input  logic                ras_n_i,
  input  logic                cas_n_i,
  input  logic                we_n_i,
  input  logic [BA_W-1:0]     ba_i,
  input  logic [ROW_W-1:0]    addr_i,
  output logic [NB-1:0]       bank_open_o,
  output logic [NB-1:0]       bank_busy_o,
  output logic [NB*ROW_W-1:0] open_row_o,
  output logic                err_valid_o,
  output logic [2:0]          err_code_o
);

  localparam int CNT_MAX = (T_RP > 8) ? T_RP : 8;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  op_e              op;
  err_e             err_d, err_q;
  logic             legal, ap_flag, full_page;
  logic [2:0]       bl_code_q;
  logic [CNT_W-1:0] bl_len;
  logic [NB-1:0]    act_v, pre_v, ap_v;

  sdram_cmd_decode u_dec (
    .cmd_i ({cs_n_i, ras_n_i, cas_n_i, we_n_i}),
    .op_o  (op)
  );

  assign ap_flag   = addr_i[AP_BIT];
  assign full_page = (bl_code_q == BL_FULL);

  sdram_rule_check #(.BA_W(BA_W)) u_chk_rules (
    .op_i        (op),
    .ba_i        (ba_i),
    .ap_i        (ap_flag),
    .full_page_i (full_page),
    .open_i      (bank_open_o),
    .busy_i      (bank_busy_o),
    .err_o       (err_d)
  );

  assign legal = (err_d == ERR_NONE);

  always_comb begin
    unique case (bl_code_q)
      3'b001:  bl_len = CNT_W'(2);
      3'b010:  bl_len = CNT_W'(4);
      3'b011:  bl_len = CNT_W'(8);
      default: bl_len = CNT_W'(1);
    endcase
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic hit;
    assign hit      = (ba_i == BA_W'(b));
    assign act_v[b] = legal && (op == OP_ACT) && hit;
    assign pre_v[b] = legal && (op == OP_PRE) && (ap_flag || hit);
    assign ap_v[b]  = legal && ((op == OP_RD) || (op == OP_WR)) && ap_flag && hit;

    sdram_bank_ctx #(.ROW_W(ROW_W), .T_RP(T_RP), .CNT_W(CNT_W)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .act_i   (act_v[b]),
      .pre_i   (pre_v[b]),
      .ap_i    (ap_v[b]),
      .row_i   (addr_i),
      .burst_i (bl_len),
      .open_o  (bank_open_o[b]),
      .busy_o  (bank_busy_o[b]),
      .row_o   (open_row_o[b*ROW_W +: ROW_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bl_code_q <= RST_BL_CODE;
      err_q     <= ERR_NONE;
    end else begin
      err_q <= err_d;
      if (legal && op == OP_LMR) bl_code_q <= addr_i[2:0];
    end
  end

  assign err_valid_o = (err_q != ERR_NONE);
  assign err_code_o  = err_q;

endmodule

// File: rtl/sdram_bank_tracker_chk.sv
module sdram_bank_tracker_chk #(
  parameter int BA_W  = 2,
  parameter int ROW_W = 12,
  parameter int T_RP  = 3,
  localparam int NB   = 1 << BA_W
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cs_n_i,
  input logic                ras_n_i,
  input logic                cas_n_i,
  input logic                we_n_i,
  input logic [BA_W-1:0]     ba_i,
  input logic [ROW_W-1:0]    addr_i,
  input logic [NB-1:0]       bank_open_o,
  input logic [NB-1:0]       bank_busy_o,
  input logic [NB*ROW_W-1:0] open_row_o,
  input logic                err_valid_o,
  input logic [2:0]          err_code_o
);

  logic [3:0] cmd;
  assign cmd = {cs_n_i, ras_n_i, cas_n_i, we_n_i};

  assert_deselect_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |=> !err_valid_o);

  assert_mode_open_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == 4'b0000 && (|bank_open_o) && !(|bank_busy_o)) |=> (err_code_o == 3'd4));

  assert_err_row_held_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_valid_o |-> $stable(open_row_o));

  assert_code_range_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_code_o <= 3'd5);

  for (genvar b = 0; b < NB; b++) begin : g_bk
    assert_open_needs_act_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(bank_open_o[b]) |-> $past(cmd == 4'b0011 && ba_i == BA_W'(b)));

    assert_close_recovers_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(bank_open_o[b]) |-> (bank_busy_o[b] || T_RP <= 1));

    assert_idle_to_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!bank_open_o[b] && !bank_busy_o[b]) |=> !bank_busy_o[b]);
  end

endmodule

bind sdram_bank_tracker sdram_bank_tracker_chk #(
  .BA_W(BA_W), .ROW_W(ROW_W), .T_RP(T_RP)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_n_i      (cs_n_i),
  .ras_n_i     (ras_n_i),
  .cas_n_i     (cas_n_i),
  .we_n_i      (we_n_i),
  .ba_i        (ba_i),
  .addr_i      (addr_i),
  .bank_open_o (bank_open_o),
  .bank_busy_o (bank_busy_o),
  .open_row_o  (open_row_o),
  .err_valid_o (err_valid_o),
  .err_code_o  (err_code_o)
);

// File: tb/sim_sdram_bank_tracker.sv
`timescale 1ns/1ps
module sim_sdram_bank_tracker;
  localparam int BA_W = 2, ROW_W = 12, T_RP = 3, NB = 4;
  localparam int BIG = 1 << 30;
  localparam logic [3:0] C_ACT = 4'b0011, C_RD = 4'b0101, C_WR = 4'b0100,
                         C_PRE = 4'b0010, C_LMR = 4'b0000, C_NOP = 4'b0111;

  logic clk_i = 0, rst_ni = 0;
  logic cs_n_i = 1, ras_n_i = 1, cas_n_i = 1, we_n_i = 1;
  logic [BA_W-1:0]     ba_i = 0;
  logic [ROW_W-1:0]    addr_i = 0;
  logic [NB-1:0]       bank_open_o, bank_busy_o;
  logic [NB*ROW_W-1:0] open_row_o;
  logic                err_valid_o;
  logic [2:0]          err_code_o;

  always #2.5 clk_i = ~clk_i;

  sdram_bank_tracker #(.BA_W(BA_W), .ROW_W(ROW_W), .T_RP(T_RP)) u0 (.*);

  int n_chk = 0, n_fail = 0;
  string cur_tag = "R1", exp_tag = "R1";

  // timestamp model
  int  e = 0;
  bit  seen = 0;
  bit  m_act [NB];
  int  m_close [NB];
  int  m_free [NB];
  logic [ROW_W-1:0] m_row [NB];
  int  m_bl = 4;
  bit  m_full = 0;
  logic [NB-1:0] x_open, x_busy;
  int  x_err = 0;

  initial for (int b = 0; b < NB; b++) begin
    m_act[b] = 0; m_close[b] = 0; m_free[b] = 0; m_row[b] = '0;
  end

  function automatic void chk(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("[TB] FAIL %s %s actual=%0h expected=%0h at edge %0d", tag, what, act, exp, e);
    end
  endfunction

  always @(posedge clk_i) if (rst_ni) begin
    logic [3:0] c;
    int code;
    bit anyb, anyo, a10;
    c = {cs_n_i, ras_n_i, cas_n_i, we_n_i};
    a10 = addr_i[10];
    code = 0;
    anyb = 0; anyo = 0;
    for (int b = 0; b < NB; b++) begin
      if (e < m_free[b]) anyb = 1;
      if (m_act[b] && e <= m_close[b]) anyo = 1;
    end
    begin
      bit sb, so;
      sb = (e < m_free[ba_i]);
      so = m_act[ba_i] && e <= m_close[ba_i];
      if (c == C_ACT)                    code = sb ? 3 : (so ? 2 : 0);
      else if (c == C_RD || c == C_WR)   code = sb ? 3 : (!so ? 1 : ((a10 && m_full) ? 5 : 0));
      else if (c == C_PRE)               code = (a10 ? anyb : sb) ? 3 : 0;
      else if (c == C_LMR)               code = anyb ? 3 : (anyo ? 4 : 0);
    end
    if (code == 0) begin
      if (c == C_ACT) begin
        m_act[ba_i] = 1; m_close[ba_i] = BIG; m_row[ba_i] = addr_i;
      end else if ((c == C_RD || c == C_WR) && a10) begin
        m_close[ba_i] = e + m_bl; m_free[ba_i] = e + m_bl + T_RP;
      end else if (c == C_PRE) begin
        for (int b = 0; b < NB; b++)
          if ((a10 || ba_i == b) && m_act[b] && e <= m_close[b]) begin
            m_close[b] = e; m_free[b] = e + T_RP;
          end
      end else if (c == C_LMR) begin
        m_full = (addr_i[2:0] == 3'b111);
        case (addr_i[2:0])
          3'b001: m_bl = 2;
          3'b010: m_bl = 4;
          3'b011: m_bl = 8;
          default: m_bl = 1;
        endcase
      end
    end
    for (int b = 0; b < NB; b++) begin
      x_open[b] = m_act[b] && e < m_close[b];
      x_busy[b] = (e + 1) < m_free[b];
    end
    x_err = code;
    exp_tag = cur_tag;
    e++;
    seen = 1;
  end

  always @(negedge clk_i) if (rst_ni && seen) begin
    chk(bank_open_o == x_open, exp_tag, "bank_open", bank_open_o, x_open);
    chk(bank_busy_o == x_busy, exp_tag, "bank_busy", bank_busy_o, x_busy);
    for (int b = 0; b < NB; b++)
      chk(open_row_o[b*ROW_W +: ROW_W] == m_row[b], exp_tag, "open_row", open_row_o[b*ROW_W +: ROW_W], m_row[b]);
    chk(err_valid_o == (x_err != 0), exp_tag, "err_valid", err_valid_o, x_err != 0);
    chk(err_code_o == x_err[2:0], exp_tag, "err_code", err_code_o, x_err);
  end

  task automatic cmd(input logic [3:0] c, input logic [1:0] b, input logic [11:0] a, input string t);
    @(negedge clk_i);
    {cs_n_i, ras_n_i, cas_n_i, we_n_i} = c;
    ba_i = b; addr_i = a; cur_tag = t;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cmd(C_NOP, 2'd0, 12'h000, cur_tag);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    // R12: reset state
    chk(bank_open_o == '0, "R12", "reset open", bank_open_o, 0);
    chk(bank_busy_o == '0, "R12", "reset busy", bank_busy_o, 0);
    chk(open_row_o == '0, "R12", "reset rows", open_row_o, 0);
    chk(!err_valid_o && err_code_o == 0, "R12", "reset err", err_code_o, 0);
    rst_ni = 1;
    idle(2);
    cmd(4'b1101, 2'd1, 12'h000, "R1");
    cmd(4'b1011, 2'd0, 12'h123, "R1");
    cmd(4'b0001, 2'd0, 12'h000, "R1");
    cmd(4'b0110, 2'd0, 12'h000, "R1");
    cmd(C_ACT, 2'd0, 12'h123, "R2");
    cmd(C_ACT, 2'd2, 12'habc, "R2");
    cmd(C_ACT, 2'd0, 12'h777, "R3");
    cmd(C_RD,  2'd1, 12'h000, "R4");
    cmd(C_WR,  2'd3, 12'h000, "R4");
    cmd(C_RD,  2'd0, 12'h010, "R4");
    cmd(C_LMR, 2'd0, 12'h002, "R10");
    cmd(C_PRE, 2'd0, 12'h000, "R5");
    cmd(C_ACT, 2'd0, 12'h055, "R6");
    cmd(C_RD,  2'd0, 12'h000, "R6");
    cmd(C_ACT, 2'd0, 12'h055, "R6");
    cmd(C_PRE, 2'd1, 12'h400, "R5");
    idle(3);
    cmd(C_PRE, 2'd1, 12'h000, "R5");
    cmd(C_ACT, 2'd1, 12'h3c3, "R5");
    cmd(C_RD,  2'd1, 12'h400, "R12");
    cmd(C_ACT, 2'd1, 12'h001, "R7");
    idle(7);
    cmd(C_LMR, 2'd0, 12'h001, "R8");
    cmd(C_ACT, 2'd3, 12'h111, "R7");
    cmd(C_WR,  2'd3, 12'h404, "R7");
    cmd(C_WR,  2'd3, 12'h000, "R7");
    idle(5);
    cmd(C_ACT, 2'd3, 12'h222, "R7");
    cmd(C_PRE, 2'd0, 12'h400, "R5");
    idle(3);
    cmd(C_LMR, 2'd0, 12'h007, "R8");
    cmd(C_ACT, 2'd0, 12'h0f0, "R9");
    cmd(C_RD,  2'd0, 12'h400, "R9");
    cmd(C_WR,  2'd0, 12'h000, "R9");
    cmd(C_PRE, 2'd0, 12'h000, "R9");
    idle(3);
    cmd(C_LMR, 2'd0, 12'h003, "R8");
    cmd(C_ACT, 2'd2, 12'h321, "R7");
    cmd(C_RD,  2'd2, 12'h400, "R7");
    cmd(C_PRE, 2'd0, 12'h400, "R6");
    cmd(C_LMR, 2'd0, 12'h000, "R6");
    idle(12);
    cmd(C_LMR, 2'd0, 12'h005, "R8");
    cmd(C_ACT, 2'd1, 12'h001, "R8");
    cmd(C_RD,  2'd1, 12'h400, "R8");
    cmd(C_ACT, 2'd1, 12'h002, "R8");
    idle(4);
    for (int i = 0; i < 800; i++) begin
      int r;
      logic [3:0] c;
      r = $urandom_range(0, 11);
      case (r)
        0, 1, 2: c = C_ACT;
        3, 4:    c = C_RD;
        5:       c = C_WR;
        6, 7:    c = C_PRE;
        8:       c = C_LMR;
        9:       c = 4'b1000 | 4'($urandom_range(0, 7));
        default: c = C_NOP;
      endcase
      cmd(c, 2'($urandom_range(0, 3)), 12'($urandom_range(0, 4095)), "R11");
    end
    idle(3);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("[TB] FAIL watchdog expired");
    finish_run();
  end

endmodule